// File: doc/BRIEF.md
# FIFO-Level Latency Allowance Scaler

This block sits next to a memory arbiter, one instance per client. It derives an effective latency allowance from the client's programmed allowance and from how much free space the client's FIFO has. A FIFO with little free space keeps the full allowance. A FIFO with more free space gets half, then a quarter, and above the top threshold it gets zero, which is the most urgent setting. The band edges come from three 8-bit free-space thresholds. Scaling takes effect only when the global enable is set and the client is marked as able to scale. In every other case the programmed allowance passes through unchanged.

The effective allowance feeds a countdown. The countdown loads on the first cycle of a new pending request. It then decrements on arbiter tick strobes until it reaches zero. At zero it raises an urgent flag, which holds until the request goes away. The arbiter reads the urgent flag to boost the client's priority.

Top module: `la_scaler`

## Requirements
- R1: With scaling active and `fifo_free_i` <= `thr_lo_i`, `alw_eff_o` equals `alw_prog_i`.
- R2: With scaling active and `thr_lo_i` < `fifo_free_i` <= `thr_mid_i`, `alw_eff_o` equals `alw_prog_i` shifted right by 1, truncated.
- R3: With scaling active and `thr_mid_i` < `fifo_free_i` <= `thr_hi_i`, `alw_eff_o` equals `alw_prog_i` shifted right by 2, truncated.
- R4: With scaling active and `fifo_free_i` > `thr_hi_i`, `alw_eff_o` is 0.
- R5: Scaling is active only when `scale_en_i` and `scale_cap_i` are both 1. Otherwise `alw_eff_o` equals `alw_prog_i`, whatever the free count and thresholds are.
- R6: The bands are tested in a fixed order: low first, then mid, then high, and the first match wins. With misordered thresholds, a free count at or below low still yields the full allowance, even when it is above mid or high.
- R7: If `req_i` is high in a cycle where it was low in the previous cycle (or where it is the first cycle after reset), `count_o` equals that cycle's `alw_eff_o` one clock later. A tick in that cycle is ignored.
- R8: While a request continues, each cycle with `tick_i` high lowers `count_o` by one. `count_o` does not drop below zero, and it does not change in cycles without a tick.
- R9: `urgent_o` is 1 exactly when the request was pending at the last clock edge and `count_o` is 0. It stays set while `req_i` stays high and clears one clock after `req_i` falls.
- R10: In every cycle with `req_i` low, `count_o` loads that cycle's `alw_eff_o` at the next clock.
- R11: After reset, `count_o` is 0 and `urgent_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alw_prog_i | input | ALW_W | Programmed latency allowance |
| thr_lo_i | input | ALW_W | Low free-space threshold |
| thr_mid_i | input | ALW_W | Mid free-space threshold |
| thr_hi_i | input | ALW_W | High free-space threshold |
| fifo_free_i | input | FREE_W | Current FIFO free count |
| scale_cap_i | input | 1 | Client supports scaling |
| scale_en_i | input | 1 | Global scaling enable |
| req_i | input | 1 | Request pending |
| tick_i | input | 1 | Arbiter tick strobe |
| alw_eff_o | output | ALW_W | Effective allowance (combinational) |
| count_o | output | ALW_W | Live countdown |
| urgent_o | output | 1 | Countdown expired for the pending request |

## Verification
The band selector is combinational, so a wrong band or a wrong shift shows up on `alw_eff_o` in the same cycle as the input change. A corrupted counter or a lost pending flag shows on `count_o` or `urgent_o` one clock after the faulty edge. The countdown is compared against a reference model on every cycle, so a single bad decrement, a missed load or a reload that was not taken is caught within one cycle. Sticky urgent behaviour is checked across long requests, and the clear timing is checked on the cycle after `req_i` falls.

// File: rtl/la_scaler_pkg.sv
package la_scaler_pkg;
  typedef enum logic [1:0] {
    BAND_FULL    = 2'd0,
    BAND_HALF    = 2'd1,
    BAND_QUARTER = 2'd2,
    BAND_ZERO    = 2'd3
  } band_e;
endpackage

// File: rtl/la_band_sel.sv
module la_band_sel
  import la_scaler_pkg::*;
#(
  parameter int ALW_W  = 8,
  parameter int FREE_W = 8
) (
  input  logic [ALW_W-1:0]  thr_lo_i,
  input  logic [ALW_W-1:0]  thr_mid_i,
  input  logic [ALW_W-1:0]  thr_hi_i,
  input  logic [FREE_W-1:0] free_i,
  input  logic              active_i,
  output band_e             band_o
);
  localparam int CMP_W = (ALW_W > FREE_W) ? ALW_W : FREE_W;

  logic [CMP_W-1:0] free_x, lo_x, mid_x, hi_x;

  always_comb begin
    free_x = CMP_W'(free_i);
    lo_x   = CMP_W'(thr_lo_i);
    mid_x  = CMP_W'(thr_mid_i);
    hi_x   = CMP_W'(thr_hi_i);
    // fixed test order: first match wins, even with misordered thresholds
    if (!active_i || free_x <= lo_x) band_o = BAND_FULL;
    else if (free_x <= mid_x)        band_o = BAND_HALF;
    else if (free_x <= hi_x)         band_o = BAND_QUARTER;
    else                             band_o = BAND_ZERO;
  end

  always_comb begin
    if (!active_i) AST_BYPASS_FULL: assert (band_o == BAND_FULL); // R5
  end
endmodule

// File: rtl/la_alw_shift.sv
module la_alw_shift
  import la_scaler_pkg::*;
#(
  parameter int ALW_W = 8
) (
  input  logic [ALW_W-1:0] prog_i,
  input  band_e            band_i,
  output logic [ALW_W-1:0] eff_o
);
  always_comb begin
    unique case (band_i)
      BAND_FULL:    eff_o = prog_i;
      BAND_HALF:    eff_o = prog_i >> 1;
      BAND_QUARTER: eff_o = prog_i >> 2;
      default:      eff_o = '0;
    endcase
  end

  always_comb begin
    AST_NEVER_ABOVE_PROG: assert (eff_o <= prog_i); // R1
  end
endmodule

// File: rtl/la_countdown.sv
module la_countdown #(
  parameter int ALW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ALW_W-1:0] eff_i,
  input  logic             req_i,
  input  logic             tick_i,
  output logic [ALW_W-1:0] cnt_o,
  output logic             urgent_o
);
  logic [ALW_W-1:0] cnt_q;
  logic             pend_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= req_i;
      if (!req_i || !pend_q)       cnt_q <= eff_i;   // idle reload or new request
      else if (tick_i && !cnt_zero) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign urgent_o = pend_q && cnt_zero;

  AST_LOAD_ON_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !pend_q |=> cnt_q == $past(eff_i)); // R7
  AST_DEC_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && pend_q && tick_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && pend_q && !tick_i |=> $stable(cnt_q)); // R8
  AST_URGENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o && req_i |=> urgent_o); // R9
  AST_URGENT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !urgent_o); // R9
  AST_IDLE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> cnt_q == $past(eff_i)); // R10
endmodule

// File: rtl/la_scaler.sv
module la_scaler
  import la_scaler_pkg::*;
#(
  parameter int ALW_W  = 8,
  parameter int FREE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ALW_W-1:0]  alw_prog_i,
  input  logic [ALW_W-1:0]  thr_lo_i,
  input  logic [ALW_W-1:0]  thr_mid_i,
  input  logic [ALW_W-1:0]  thr_hi_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  input  logic              scale_cap_i,
  input  logic              scale_en_i,
  input  logic              req_i,
  input  logic              tick_i,
  output logic [ALW_W-1:0]  alw_eff_o,
  output logic [ALW_W-1:0]  count_o,
  output logic              urgent_o
);
  band_e            band;
  logic [ALW_W-1:0] eff;
  logic             active;

  assign active = scale_en_i && scale_cap_i;

  la_band_sel #(.ALW_W(ALW_W), .FREE_W(FREE_W)) u_band (
    .thr_lo_i (thr_lo_i),
    .thr_mid_i(thr_mid_i),
    .thr_hi_i (thr_hi_i),
    .free_i   (fifo_free_i),
    .active_i (active),
    .band_o   (band)
  );

  la_alw_shift #(.ALW_W(ALW_W)) u_shift (
    .prog_i(alw_prog_i),
    .band_i(band),
    .eff_o (eff)
  );

  la_countdown #(.ALW_W(ALW_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eff_i   (eff),
    .req_i   (req_i),
    .tick_i  (tick_i),
    .cnt_o   (count_o),
    .urgent_o(urgent_o)
  );

  assign alw_eff_o = eff;

  AST_URGENT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> count_o == '0); // R9
endmodule

// File: tb/la_scaler_test.sv
`timescale 1ns/1ps
module la_scaler_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] alw_prog_i = '0, thr_lo_i = '0, thr_mid_i = '0, thr_hi_i = '0;
  logic [7:0] fifo_free_i = '0;
  logic       scale_cap_i = 1'b0, scale_en_i = 1'b0, req_i = 1'b0, tick_i = 1'b0;
  logic [7:0] alw_eff_o, count_o;
  logic       urgent_o;

  int n_chk = 0, n_err = 0;
  int m_cnt = 0;
  bit m_pend = 0;

  always #2.5 clk_i = ~clk_i;

  la_scaler uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .alw_prog_i(alw_prog_i),
    .thr_lo_i(thr_lo_i), .thr_mid_i(thr_mid_i), .thr_hi_i(thr_hi_i),
    .fifo_free_i(fifo_free_i), .scale_cap_i(scale_cap_i), .scale_en_i(scale_en_i),
    .req_i(req_i), .tick_i(tick_i), .alw_eff_o(alw_eff_o), .count_o(count_o),
    .urgent_o(urgent_o)
  );

  function automatic int eff_ref(int p, int lo, int mid, int hi, int fr, bit cap, bit en);
    if (!(cap && en) || fr <= lo) return p;
    if (fr <= mid) return p >> 1;
    if (fr <= hi)  return p >> 2;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string band_tag();
    int fr = fifo_free_i;
    if (!(scale_cap_i && scale_en_i)) return "R5";
    if (fr <= thr_lo_i) return (thr_lo_i > thr_mid_i || thr_lo_i > thr_hi_i) ? "R6" : "R1";
    if (fr <= thr_mid_i) return "R2";
    if (fr <= thr_hi_i) return "R3";
    return "R4";
  endfunction

  // apply one cycle of inputs, check comb output, then registered outputs
  task automatic step(int p, int lo, int mid, int hi, int fr, bit cap, bit en, bit rq, bit tk);
    int e;
    alw_prog_i = 8'(p); thr_lo_i = 8'(lo); thr_mid_i = 8'(mid); thr_hi_i = 8'(hi);
    fifo_free_i = 8'(fr); scale_cap_i = cap; scale_en_i = en; req_i = rq; tick_i = tk;
    #1;
    e = eff_ref(p, lo, mid, hi, fr, cap, en);
    check(band_tag(), alw_eff_o, e);
    if (!rq || !m_pend) m_cnt = e;
    else if (tk && m_cnt != 0) m_cnt = m_cnt - 1;
    m_pend = rq;
    @(negedge clk_i);
    check(rq && !m_pend ? "R10" : (rq ? "R8" : "R10"), count_o, m_cnt);
    check("R9", urgent_o, (m_pend && m_cnt == 0) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #12;
    check("R11", count_o, 0);
    check("R11", urgent_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed bands, prog 200, thresholds 40/100/180
    step(200, 40, 100, 180, 40, 1, 1, 0, 0);   // R1 boundary
    step(200, 40, 100, 180, 41, 1, 1, 0, 0);   // R2
    step(200, 40, 100, 180, 100, 1, 1, 0, 0);  // R2 boundary
    step(200, 40, 100, 180, 180, 1, 1, 0, 0);  // R3 boundary
    step(200, 40, 100, 180, 181, 1, 1, 0, 0);  // R4
    step(3, 40, 100, 180, 50, 1, 1, 0, 0);     // R2 truncation -> 1
    step(3, 40, 100, 180, 150, 1, 1, 0, 0);    // R3 truncation -> 0
    step(200, 40, 100, 180, 255, 0, 1, 0, 0);  // R5 no capability
    step(200, 40, 100, 180, 255, 1, 0, 0, 0);  // R5 global off
    step(200, 150, 20, 10, 120, 1, 1, 0, 0);   // R6 low wins
    step(200, 150, 20, 10, 160, 1, 1, 0, 0);   // R6 falls to zero band

    // R7: load with tick ignored, R8 countdown, R9 sticky urgent
    step(5, 40, 100, 180, 10, 1, 1, 1, 1);     // R7 load 5
    for (int i = 0; i < 3; i++) step(5, 40, 100, 180, 10, 1, 1, 1, 0); // R8 hold
    for (int i = 0; i < 8; i++) step(5, 40, 100, 180, 10, 1, 1, 1, 1); // R8 to zero, stays
    for (int i = 0; i < 4; i++) step(5, 40, 100, 180, 10, 1, 1, 1, 0); // R9 sticky
    step(5, 40, 100, 180, 10, 1, 1, 0, 0);     // R9 clears next clock
    step(0, 40, 100, 180, 10, 1, 1, 1, 0);     // R7 load zero -> urgent at once
    step(0, 40, 100, 180, 10, 1, 1, 0, 1);     // R10 idle reload

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int lo = $urandom_range(0, 90);
      int mid = lo + $urandom_range(0, 80);
      int hi = mid + $urandom_range(0, 80);
      bit rq = (i % 40) < 30;
      if (($urandom % 16) == 0) begin lo = $urandom_range(0, 255); mid = $urandom_range(0, 255); hi = $urandom_range(0, 255); end
      step(($urandom % 4 == 0) ? $urandom_range(0, 7) : $urandom_range(0, 255),
           lo, mid, hi, $urandom_range(0, 255),
           ($urandom % 8) != 0, ($urandom % 8) != 0, rq, ($urandom % 3) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule